// File: doc/BRIEF.md
# Sleep Entry/Exit Sequencer for a Synchronous SRAM Model

This block decides when the SRAM model is powered down. It takes a sleep request that may change at any moment relative to the clock and brings it into the clock domain through a chain of flops. The last flop of that chain is the sequencer's own state register. A request that has been sampled therefore puts the block to sleep after exactly two clock edges. Release is timed the same way. While the block sleeps it refuses every access, holds the data outputs in high impedance and so leaves the array untouched. When an access is caught mid-flight at the moment of entry, it signals that the access is dropped.

On release the block does not become usable at once. It first runs a recovery interval of `RECOV_CYC` clocks. The select must stay low for all of it, and accesses are still refused. If a select arrives inside that window, a violation pulse is raised. A new request during recovery sends the block straight back to sleep. The controller gates its chip select through `grant` and watches `inhibit`, `asleep` and `recov_viol`. All ports are plain control and status pins, and no data stream passes through the block.

Top module: `slp_seq`

## Requirements
- R1: After reset (`rst_n` low, active-low, asynchronous), `asleep`, `inhibit`, `q_hiz`, `abandon` and `recov_viol` are all 0.
- R2: Suppose `sleep_req` is held high and is first sampled high at clock edge k. Then `asleep` is still 0 after edge k and is 1 after edge k+1, so sleep is entered in two clocks.
- R3: While `asleep` is 1, `q_hiz` is 1, `inhibit` is 1 and `grant` is 0 whatever `sel` does. This leaves stored data unchanged. The block stays asleep for as long as the request stays high.
- R4: `abandon` is 1 for exactly the first cycle of a sleep period entered from the awake state, which drops any access in flight. It is 0 at all other times.
- R5: Suppose the request is first sampled low at edge m. Then `asleep` is still 1 after edge m and is 0 after edge m+1. `inhibit` then stays 1 for `RECOV_CYC` cycles and is 0 after edge m+1+`RECOV_CYC`.
- R6: When awake and not recovering, `grant` equals `sel` in the same cycle. `recov_viol` stays 0.
- R7: If `sel` is high at an edge during recovery, `recov_viol` is 1 for the following cycle and `grant` stays 0. The length of the recovery window is unchanged.
- R8: If the request is sampled high again during recovery, `asleep` returns to 1 two edges later. `inhibit` never falls in between, and `abandon` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| sel | input | 1 | Combined chip select from the controller, high = access |
| grant | output | 1 | Select passed to the array, forced low when inhibited |
| asleep | output | 1 | Sleep status |
| inhibit | output | 1 | Access refused (asleep or recovering) |
| q_hiz | output | 1 | Data outputs held in high impedance |
| abandon | output | 1 | One-cycle pulse: access in flight dropped at sleep entry |
| recov_viol | output | 1 | One-cycle pulse: select seen during recovery |

## Verification
Every result is due on a fixed edge. `asleep` moves on the second edge after the request is sampled. `abandon` shows in the first sleeping cycle. `recov_viol` follows one edge after the offending select. `inhibit` clears `RECOV_CYC`+1 edges after the release is sampled. `grant` is combinational within the cycle. The bench drives inputs on the falling edge and steps one rising edge at a time. It samples on the next falling edge, so each check lands on the exact cycle counted from these latencies. Checks are also made one cycle early, where the old value must still hold.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_RECOVER = 2'd2
  } slp_state_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slp_timer.sv
module slp_timer #(
  parameter int unsigned RECOV_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RECOV_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= LOAD_VAL;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_VAL);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       tmr_done,
  output slp_state_t state,
  output logic       tmr_load,
  output logic       abandon
);
  slp_state_t nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    unique case (state)
      ST_AWAKE:   if (req_s) nxt = ST_ASLEEP;
      ST_ASLEEP:  if (!req_s) begin
                    nxt      = ST_RECOVER;
                    tmr_load = 1'b1;
                  end
      ST_RECOVER: if (req_s)         nxt = ST_ASLEEP;
                  else if (tmr_done) nxt = ST_AWAKE;
      default:    nxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_AWAKE;
      abandon <= 1'b0;
    end else begin
      state   <= nxt;
      abandon <= (state == ST_AWAKE) && req_s;
    end
  end

  // R5: leaving sleep always passes through recovery
  a_r5_exit_via_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ASLEEP && state != ST_ASLEEP) |-> state == ST_RECOVER);
  // R8: awake is reached only from recovery
  a_r8_awake_from_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && $past(state) != ST_AWAKE) |-> $past(state) == ST_RECOVER);
  // R4: abandon only in a sleep cycle
  a_r4_abandon_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |-> state == ST_ASLEEP);
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int unsigned ENTRY_DLY = 2,
  parameter int unsigned RECOV_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic sel,
  output logic grant,
  output logic asleep,
  output logic inhibit,
  output logic q_hiz,
  output logic abandon,
  output logic recov_viol
);
  localparam int unsigned SYNC_STAGES = (ENTRY_DLY < 2) ? 1 : ENTRY_DLY - 1;

  logic       req_s;
  logic       tmr_done;
  logic       tmr_load;
  slp_state_t state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req), .q_sync(req_s)
  );

  slp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .tmr_done(tmr_done),
    .state(state), .tmr_load(tmr_load), .abandon(abandon)
  );

  slp_timer #(.RECOV_CYC(RECOV_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .run(state == ST_RECOVER), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recov_viol <= 1'b0;
    else        recov_viol <= (state == ST_RECOVER) && sel;
  end

  assign asleep  = (state == ST_ASLEEP);
  assign inhibit = (state != ST_AWAKE);
  assign q_hiz   = asleep;
  assign grant   = sel && !inhibit;

  // R3: no access reaches the array while asleep
  a_r3_no_grant_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!grant && q_hiz));
  // R7: violation only follows a select
  a_r7_viol_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
    recov_viol |-> $past(sel));
  // R5: sleep release is followed by inhibit
  a_r5_fell_asleep_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> inhibit);
endmodule

// File: tb/slp_seq_test.sv
module slp_seq_test;
  localparam int R = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic sel = 1'b0;
  logic grant, asleep, inhibit, q_hiz, abandon, recov_viol;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  slp_seq #(.ENTRY_DLY(2), .RECOV_CYC(R)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sel(sel),
    .grant(grant), .asleep(asleep), .inhibit(inhibit), .q_hiz(q_hiz),
    .abandon(abandon), .recov_viol(recov_viol)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 inhibit", inhibit, 1'b0);
    chk("R1 q_hiz", q_hiz, 1'b0);
    chk("R1 abandon", abandon, 1'b0);
    chk("R1 recov_viol", recov_viol, 1'b0);
  endtask

  task automatic t_grant_awake();
    sel = 1'b1; #1;
    chk("R6 grant follows sel high", grant, 1'b1);
    tick();
    chk("R6 no viol when awake", recov_viol, 1'b0);
    sel = 1'b0; #1;
    chk("R6 grant follows sel low", grant, 1'b0);
  endtask

  task automatic t_entry();
    sleep_req = 1'b1;
    tick();
    chk("R2 not yet asleep", asleep, 1'b0);
    tick();
    chk("R2 asleep after two edges", asleep, 1'b1);
    chk("R4 abandon first cycle", abandon, 1'b1);
    sel = 1'b1; #1;
    chk("R3 grant blocked", grant, 1'b0);
    chk("R3 q_hiz", q_hiz, 1'b1);
    tick();
    chk("R4 abandon one cycle", abandon, 1'b0);
    chk("R3 still asleep", asleep, 1'b1);
    sel = 1'b0;
    tick();
    chk("R3 held asleep", asleep, 1'b1);
  endtask

  task automatic t_exit(input logic poke);
    sleep_req = 1'b0;
    tick();
    chk("R5 still asleep", asleep, 1'b1);
    tick();
    chk("R5 awake status", asleep, 1'b0);
    chk("R5 recovery inhibit", inhibit, 1'b1);
    for (int i = 1; i < R; i++) begin
      if (poke && i == 2) sel = 1'b1;
      #1;
      if (poke && i == 2) chk("R7 grant blocked in recovery", grant, 1'b0);
      tick();
      if (poke && i == 2) begin
        chk("R7 viol pulse", recov_viol, 1'b1);
        sel = 1'b0;
      end else if (poke && i == 3) begin
        chk("R7 viol one cycle", recov_viol, 1'b0);
      end
      chk("R5 inhibit held", inhibit, 1'b1);
    end
    tick();
    chk("R5 inhibit cleared", inhibit, 1'b0);
    chk("R7 window not extended", asleep, 1'b0);
  endtask

  task automatic t_rerequest();
    sleep_req = 1'b1;
    tick(); tick();
    sleep_req = 1'b0;
    tick(); tick();
    chk("R8 recovering", inhibit, 1'b1);
    sleep_req = 1'b1;
    tick();
    chk("R8 not yet asleep", asleep, 1'b0);
    chk("R8 inhibit held", inhibit, 1'b1);
    tick();
    chk("R8 back asleep", asleep, 1'b1);
    chk("R8 no abandon", abandon, 1'b0);
    sleep_req = 1'b0;
    tick(); tick();
    for (int i = 0; i < R; i++) tick();
    chk("R8 final awake", inhibit, 1'b0);
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_awake();
        t_entry();
        t_exit(1'b0);
        t_entry();
        t_exit(1'b1);
        t_rerequest();
        t_grant_awake();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule